// File: doc/BRIEF.md
# Token-Ring Dual-Clock FIFO

This block moves data words from a writer clock domain to an unrelated reader clock domain. Storage is a ring of cells. The writer side passes a one-hot token from cell to cell to pick the slot that the next accepted word goes into. The reader side passes its own token around the same cells to pick the slot it presents next. The data registers never pass through a synchronizer. Each cell instead carries a status bit on each side, which flips once per use. Only these status bits cross the clock boundary, through multi-stage synchronizers.

Each side keeps an occupancy counter that is correct or pessimistic. The writer's counter goes up at once on a write and comes down only when the reader's flip of that cell arrives through the synchronizer. The reader's counter comes down at once on a read and goes up only when the writer's flip arrives. The full flag therefore never lets a write land on an unread cell. The empty flag never lets a read take a cell that has not been written. Because of the synchronizer delay, a word is known to be stable long before the reader can select it.

Both edges of the block are valid/ready streams. On the write side, a word is taken on a writer clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is the inverse of `wr_full`, and while it is low the writer must hold or retry. On the read side, `rd_data` is the oldest word whenever `rd_valid` is high. The word is consumed on a reader clock edge where `rd_ready` is also high. The reader may keep `rd_ready` low for any length of time, and the word stays put while it does.

Top module: `tfr_token_fifo`

## Requirements
- R1: While either reset is low and after it is released, with no writes yet, `rd_empty` is 1, `rd_valid` is 0, `wr_full` is 0 and `wr_ready` is 1. Both tokens start at cell 0.
- R2: Words leave in the order they were accepted, with values unchanged, including across many wraps of the ring.
- R3: A write attempted while `wr_full` is 1 is ignored. No extra word ever appears at the read side, and `wr_full` stays 1 while no read takes place.
- R4: A read attempted while `rd_valid` is 0 is ignored. The next word written is still the next word read, and `rd_valid` falls only on an edge where a read was accepted.
- R5: With no reads, `wr_full` becomes 1 right after the writer clock edge that accepts the DEPTH-th word, and not before. It rises only after an edge where `wr_valid` was high.
- R6: After a word is accepted into an empty FIFO, `rd_valid` is still 0 at the first reader clock low phase that follows. It is 1 within SYNC_STAGES+3 reader clock low phases.
- R7: After a read from a full FIFO, `wr_full` is still 1 at the first writer clock low phase after that reader edge. It returns to 0 within SYNC_STAGES+4 writer clock low phases.
- R8: While `rd_valid` is 1 and `rd_ready` is 0, on the next reader edge `rd_valid` stays 1 and `rd_data` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Writer clock |
| wr_rst_n | input | 1 | Writer-domain reset, active low, asynchronous |
| wr_valid | input | 1 | Writer offers a word |
| wr_data | input | WIDTH | Word offered by the writer |
| wr_ready | output | 1 | A word is accepted on this edge if offered |
| wr_full | output | 1 | Conservative full flag |
| rd_clk | input | 1 | Reader clock |
| rd_rst_n | input | 1 | Reader-domain reset, active low, asynchronous |
| rd_ready | input | 1 | Reader takes the presented word |
| rd_data | output | WIDTH | Oldest word, selected by the reader token |
| rd_valid | output | 1 | `rd_data` holds a word |
| rd_empty | output | 1 | Conservative empty flag |

## Verification
Flags on the side that acts change at once: `wr_full` changes right after the writer edge that accepts a word, and `rd_valid` drops right after the reader edge that consumes one. A change made by the other side shows up only after the status flip of a cell passes through its synchronizer stages and then updates the counter, which is SYNC_STAGES+1 edges of the destination clock. The bench drives and samples on falling edges. For R6 and R7 it first checks that the flag has not yet moved, then counts falling edges of the destination clock up to the stated bound. A scoreboard queue checks order and values as words are popped.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
  // smallest ring size the token scheme is designed for
  localparam int unsigned TFR_MIN_DEPTH = 4;

  // bits needed to hold an occupancy count of 0..depth
  function automatic int unsigned tfr_cnt_bits(input int unsigned depth);
    return $clog2(depth) + 1;
  endfunction
endpackage

// File: rtl/tfr_sync.sv
module tfr_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tfr_put_side.sv
module tfr_put_side
  import tfr_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  output logic             full,
  input  logic [DEPTH-1:0] taken_sync,
  output logic [DEPTH-1:0] filled_flip,
  output logic [WIDTH-1:0] cell_q [DEPTH]
);
  localparam int unsigned CW = tfr_cnt_bits(DEPTH);

  logic [DEPTH-1:0] token;
  logic [DEPTH-1:0] taken_seen;
  logic [DEPTH-1:0] taken_evt;
  logic [CW-1:0]    occ;
  logic             accept;

  assign full      = (occ == CW'(DEPTH));
  assign in_ready  = !full;
  assign accept    = in_valid && !full;
  assign taken_evt = taken_sync ^ taken_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      token       <= DEPTH'(1);
      filled_flip <= '0;
      taken_seen  <= '0;
      occ         <= '0;
    end else begin
      taken_seen <= taken_sync;
      occ        <= occ + CW'(accept) - CW'($countones(taken_evt));
      if (accept) begin
        filled_flip <= filled_flip ^ token;
        token       <= {token[DEPTH-2:0], token[DEPTH-1]};
      end
    end
  end

  // storage cells, written only when holding the writer token
  for (genvar c = 0; c < DEPTH; c++) begin : g_cell
    always_ff @(posedge clk) begin
      if (accept && token[c]) cell_q[c] <= in_data;
    end
  end
endmodule

// File: rtl/tfr_get_side.sv
module tfr_get_side
  import tfr_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             empty,
  output logic [WIDTH-1:0] out_data,
  input  logic [DEPTH-1:0] filled_sync,
  output logic [DEPTH-1:0] taken_flip,
  input  logic [WIDTH-1:0] cell_q [DEPTH]
);
  localparam int unsigned CW = tfr_cnt_bits(DEPTH);

  logic [DEPTH-1:0] token;
  logic [DEPTH-1:0] filled_seen;
  logic [DEPTH-1:0] filled_evt;
  logic [CW-1:0]    avail;
  logic             take;

  assign empty      = (avail == '0);
  assign out_valid  = !empty;
  assign take       = out_ready && !empty;
  assign filled_evt = filled_sync ^ filled_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      token       <= DEPTH'(1);
      taken_flip  <= '0;
      filled_seen <= '0;
      avail       <= '0;
    end else begin
      filled_seen <= filled_sync;
      avail       <= avail + CW'($countones(filled_evt)) - CW'(take);
      if (take) begin
        taken_flip <= taken_flip ^ token;
        token      <= {token[DEPTH-2:0], token[DEPTH-1]};
      end
    end
  end

  // AND-OR multiplexer steered by the one-hot reader token
  always_comb begin
    out_data = '0;
    for (int c = 0; c < DEPTH; c++) begin
      if (token[c]) out_data = out_data | cell_q[c];
    end
  end
endmodule

// File: rtl/tfr_token_fifo.sv
module tfr_token_fifo #(
  parameter int unsigned DEPTH       = 8,
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_ready,
  output logic             wr_full,
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             rd_empty
);
  logic [DEPTH-1:0] filled_flip, filled_sync;
  logic [DEPTH-1:0] taken_flip, taken_sync;
  logic [WIDTH-1:0] cell_q [DEPTH];

  tfr_put_side #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_put (
    .clk(wr_clk), .rst_n(wr_rst_n),
    .in_valid(wr_valid), .in_data(wr_data),
    .in_ready(wr_ready), .full(wr_full),
    .taken_sync(taken_sync), .filled_flip(filled_flip),
    .cell_q(cell_q)
  );

  tfr_sync #(.WIDTH(DEPTH), .STAGES(SYNC_STAGES)) u_sync_to_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(filled_flip), .q(filled_sync)
  );

  tfr_sync #(.WIDTH(DEPTH), .STAGES(SYNC_STAGES)) u_sync_to_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(taken_flip), .q(taken_sync)
  );

  tfr_get_side #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_get (
    .clk(rd_clk), .rst_n(rd_rst_n),
    .out_ready(rd_ready), .out_valid(rd_valid), .empty(rd_empty),
    .out_data(rd_data),
    .filled_sync(filled_sync), .taken_flip(taken_flip),
    .cell_q(cell_q)
  );
endmodule

// File: rtl/tfr_checker.sv
module tfr_checker #(
  parameter int unsigned WIDTH = 16
) (
  input logic             wr_clk,
  input logic             wr_rst_n,
  input logic             wr_valid,
  input logic             wr_full,
  input logic             rd_clk,
  input logic             rd_rst_n,
  input logic             rd_ready,
  input logic [WIDTH-1:0] rd_data,
  input logic             rd_valid,
  input logic             rd_empty
);
  // R1: reset leaves the read side empty
  a_r1_reset_empty: assert property (@(posedge rd_clk)
    !rd_rst_n |=> rd_empty);

  // R5: full only rises after the writer offered a word
  a_r5_full_needs_write: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $rose(wr_full) |-> $past(wr_valid));

  // R4: valid only falls after an accepted read
  a_r4_valid_drop_on_read: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $fell(rd_valid) |-> $past(rd_ready));

  // R8: a stalled word holds
  a_r8_stall_hold: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

bind tfr_token_fifo tfr_checker #(.WIDTH(WIDTH)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_full(wr_full),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_ready(rd_ready), .rd_data(rd_data),
  .rd_valid(rd_valid), .rd_empty(rd_empty)
);

// File: tb/tfr_token_fifo_tb.sv
module tfr_token_fifo_tb;
  localparam int DEPTH = 8;
  localparam int WIDTH = 16;
  localparam int SYNC  = 2;

  logic             wr_clk = 0, rd_clk = 0;
  logic             wr_rst_n = 0, rd_rst_n = 0;
  logic             wr_valid = 0;
  logic [WIDTH-1:0] wr_data = '0;
  logic             wr_ready, wr_full;
  logic             rd_ready = 0;
  logic [WIDTH-1:0] rd_data;
  logic             rd_valid, rd_empty;

  always #4   wr_clk = ~wr_clk;   // 125 MHz
  always #6.5 rd_clk = ~rd_clk;   // unrelated reader clock

  tfr_token_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SYNC_STAGES(SYNC)) u_dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_full(wr_full),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_empty(rd_empty)
  );

  int checks = 0, errors = 0;
  logic [WIDTH-1:0] sb_q [$];
  int budget = 0;        // reads allowed: -1 unlimited
  bit rnd_rd = 0, force_rd = 0;
  logic [15:0] lf_rd = 16'hACE1, lf_wr = 16'h1D2B;

  function automatic logic [15:0] lfsr(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: offer one word, record it once accepted
  task automatic put(input logic [WIDTH-1:0] d);
    @(negedge wr_clk);
    while (!wr_ready) @(negedge wr_clk);
    wr_valid = 1; wr_data = d;
    sb_q.push_back(d);
    @(negedge wr_clk);
    wr_valid = 0;
  endtask

  // monitor: pop from scoreboard whenever a word is taken
  initial begin
    forever begin
      @(negedge rd_clk);
      lf_rd = lfsr(lf_rd);
      rd_ready = 0;
      if (rd_valid && budget != 0 && (!rnd_rd || lf_rd[0])) begin
        if (sb_q.size() == 0)
          chk(0, "R2", "unexpected word", int'(rd_data), -1);
        else
          chk(rd_data == sb_q[0], "R2", "word order/value", int'(rd_data), int'(sb_q[0]));
        if (sb_q.size() != 0) void'(sb_q.pop_front());
        rd_ready = 1;
        if (budget > 0) budget--;
      end else if (force_rd && budget != 0) begin
        rd_ready = 1;   // read attempt on an empty FIFO (R4)
      end
    end
  end

  task automatic summary_and_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    errors++;
    $display("FAIL watchdog expired");
    summary_and_end();
  end

  initial begin
    int n;
    // R1: reset state
    repeat (3) @(negedge rd_clk);
    chk(rd_empty == 1 && rd_valid == 0, "R1", "empty in reset", int'(rd_valid), 0);
    chk(wr_full == 0 && wr_ready == 1, "R1", "not full in reset", int'(wr_full), 0);
    wr_rst_n = 1; rd_rst_n = 1;
    repeat (4) @(negedge rd_clk);
    chk(rd_empty == 1 && rd_valid == 0, "R1", "empty after reset", int'(rd_valid), 0);
    chk(wr_full == 0 && wr_ready == 1, "R1", "ready after reset", int'(wr_ready), 1);

    // R6: latency of the first word
    put(16'hA5A5);
    @(negedge rd_clk);
    chk(rd_valid == 0, "R6", "valid too early", int'(rd_valid), 0);
    n = 1;
    while (!rd_valid && n < 12) begin @(negedge rd_clk); n++; end
    chk(rd_valid == 1 && n <= SYNC + 3, "R6", "valid latency (low phases)", n, SYNC + 3);
    chk(rd_data == 16'hA5A5, "R1", "first word in cell 0", int'(rd_data), 16'hA5A5);
    budget = -1;
    while (sb_q.size() != 0) @(negedge rd_clk);
    budget = 0;
    repeat (20) @(negedge wr_clk);

    // R5: fill without reads
    for (int i = 0; i < DEPTH; i++) begin
      chk(wr_full == 0, "R5", "full before depth words", int'(wr_full), 0);
      put(WIDTH'(16'h1000 + i));
    end
    chk(wr_full == 1 && wr_ready == 0, "R5", "full after depth words", int'(wr_full), 1);

    // R3: write while full is ignored
    wr_valid = 1; wr_data = 16'hDEAD;
    repeat (6) @(negedge wr_clk);
    chk(wr_full == 1, "R3", "full holds during ignored write", int'(wr_full), 1);
    wr_valid = 0;

    // R7: one read frees space after the sync delay
    budget = 1;
    while (budget != 0) @(negedge rd_clk);
    @(posedge rd_clk);
    @(negedge wr_clk);
    chk(wr_full == 1, "R7", "full still set right after read", int'(wr_full), 1);
    n = 1;
    while (wr_full && n < 12) begin @(negedge wr_clk); n++; end
    chk(wr_full == 0 && n <= SYNC + 4, "R7", "full release latency", n, SYNC + 4);

    // R3/R2: drain, no ghost word may appear
    budget = -1;
    while (sb_q.size() != 0) @(negedge rd_clk);
    repeat (8) @(negedge rd_clk);
    chk(rd_empty == 1 && rd_valid == 0, "R3", "empty after drain, ignored word absent",
        int'(rd_valid), 0);

    // R4: reads attempted while empty are ignored
    force_rd = 1;
    repeat (10) @(negedge rd_clk);
    chk(rd_empty == 1, "R4", "still empty after read attempts", int'(rd_empty), 1);
    put(16'h0B0B);
    put(16'h0C0C);
    n = 0;
    while (sb_q.size() != 0 && n < 40) begin @(negedge rd_clk); n++; end
    chk(sb_q.size() == 0, "R4", "words after ignored reads delivered", sb_q.size(), 0);
    force_rd = 0;
    repeat (20) @(negedge wr_clk);

    // R2/R8: irregular traffic on both sides, many ring wraps
    rnd_rd = 1;
    for (int i = 0; i < 300; i++) begin
      lf_wr = lfsr(lf_wr);
      if (lf_wr[1]) @(negedge wr_clk);
      put(WIDTH'(i * 16'h0137) ^ lf_wr);
    end
    n = 0;
    while (sb_q.size() != 0 && n < 4000) begin @(negedge rd_clk); n++; end
    chk(sb_q.size() == 0, "R2", "all stream words delivered", sb_q.size(), 0);
    repeat (10) @(negedge rd_clk);
    chk(rd_empty == 1 && wr_full == 0, "R2", "idle flags after stream", int'(rd_empty), 1);
    summary_and_end();
  end
endmodule